// File: doc/BRIEF.md
# Receive Ring Routing Selector

This block decides where a received wireless frame goes. For each frame it takes the classification word stored for the peer, the frame's kind, the outcome of the flow search, the low bits of a Toeplitz hash, and two flags: whether the frame spans several buffers and whether it is a multicast echo. It returns three ring choices. The first is the ring that supplies the data buffer. The second is the ring that the DMA engine pushes the frame to. The third is the 5-bit exit ring that the reorder engine uses once reordering is done.

The ring pair comes either from the peer word or from per-kind configuration. A multicast echo, or an illegal ring code, turns the frame into a drop. The exit ring starts as the word's code. If flow search missed, a hash fallback can replace it. Codes with no physical ring are then sent through a remap table. Last, a gated PPE override can replace the whole result with one programmed code. All results are registered one cycle after an input strobe.

Top module: `rx_ring_router`

## Requirements
- R1: While reset is asserted, and after it, out_valid, out_err and all ring outputs are zero until the first accepted frame.
- R2: A frame with in_valid high appears on the outputs, with out_valid high, exactly one clock later. After a cycle with in_valid low, out_valid and out_err are low and the three ring outputs keep their previous values.
- R3: The frame kind is 0 for unicast data, 1 for multicast data, 2 for block-ack-request control and 3 for any other frame. For kinds 0 to 2, word bit 8+kind is the override. When that bit is set, the source ring is word[13:11] and the destination ring is word[16:14]. When it is clear, and always for kind 3, the rings are cfg_src_rings[3k+2:3k] and cfg_dst_rings[3k+2:3k] for kind k.
- R4: Word bit 7 is the hash fallback enable. If it is set, flow_hit is low and word[6:5] is 0, the pre-remap exit code is {1, hash[3:0]}.
- R5: Under the same enable and flow miss, a nonzero word[6:5] gives the pre-remap exit code {word[6:5], hash[2:0]}. A flow hit, or a clear bit 7, leaves the pre-remap code at word[4:0].
- R6: A pre-remap code of 11 or more is replaced by entry c of the remap table, cfg_remap[5c+4:5c]. So is a code c from 7 to 10 whose presence bit cfg_ring_present[c-7] is clear. Codes 0 to 6, and present codes 7 to 10, pass unchanged.
- R7: When word bit 20 (use PPE) and word bit 21 (PPE routing enable) are both set, out_exit_ring is cfg_ppe_ring. This happens after the fallback and the remap, and it is skipped when multi_buf and cfg_mbuf_ppe_off are both high. A clear bit 21 disables the override whatever bit 20 says.
- R8: A multicast frame (kind 1) with word bit 17 set and echo_flag high gets destination ring 0, which means release and drop. Its source ring is unchanged.
- R9: A selected source code of 6 or 7, or a selected destination code of 7, forces destination ring 0 and raises out_err for that one output cycle. The source code is passed through as selected.
- R10: Word bits 18, 19 and 31:22 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Frame attributes are valid this cycle |
| class_word | input | 32 | Per-peer classification word |
| frame_kind | input | 2 | 0 unicast data, 1 multicast data, 2 block-ack-request, 3 other |
| flow_hit | input | 1 | Flow search succeeded |
| flow_hash | input | 4 | Low four bits of the Toeplitz hash |
| multi_buf | input | 1 | Frame needs more than one buffer |
| echo_flag | input | 1 | Frame was found to be a multicast echo |
| cfg_src_rings | input | 12 | Default source ring per kind, 3 bits each |
| cfg_dst_rings | input | 12 | Default destination ring per kind, 3 bits each |
| cfg_ppe_ring | input | 5 | Exit ring code used for the PPE override |
| cfg_remap | input | 160 | Remap table, 32 entries of 5 bits |
| cfg_ring_present | input | 4 | Presence of exit rings 7 to 10 |
| cfg_mbuf_ppe_off | input | 1 | Skip the PPE override for multi-buffer frames |
| out_valid | output | 1 | Registered results are valid |
| out_src_ring | output | 3 | Buffer source ring |
| out_dst_ring | output | 3 | DMA destination ring |
| out_exit_ring | output | 5 | Reorder exit ring |
| out_err | output | 1 | Illegal ring code was selected |

## Verification
The bench targets the places where the layers interact. A fallback code with zero peer bits always lands in the remap range. A PPE override must win over the remap but lose to the multi-buffer disable and to a clear routing enable. A design that applied the remap after the PPE override, or that tested only the use-PPE bit, would put the wrong exit ring on frames routed to the accelerator. Echo drops on unicast frames, override bits on kind 3, illegal ring codes taken from configuration rather than the word, and reserved bits set to one are each aimed at. A design that decoded the wrong bit would misroute those frames, and one that missed the illegal code would report no error or fail to drop the frame.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  localparam int RING_W        = 3;
  localparam int EXIT_W        = 5;
  localparam int PEER_W        = 2;
  localparam int NUM_OVR_KINDS = 3;
  localparam int FIRST_OPT     = 7;
  localparam int OPT_RINGS     = 4;

  localparam logic [RING_W-1:0] SRC_MAX     = 3'd5;
  localparam logic [RING_W-1:0] DST_MAX     = 3'd6;
  localparam logic [RING_W-1:0] DST_RELEASE = 3'd0;
  localparam logic [1:0]        KIND_MCAST  = 2'd1;

  // Peer classification word, most significant field first
  typedef struct packed {
    logic [9:0]        rsvd_hi;
    logic              ppe_gate;
    logic              ppe_req;
    logic [1:0]        rsvd_mid;
    logic              echo_drop;
    logic [RING_W-1:0] dst;
    logic [RING_W-1:0] src;
    logic [NUM_OVR_KINDS-1:0] ovr;
    logic              fb_en;
    logic [PEER_W-1:0] peer_hi;
    logic [EXIT_W-1:0] exit_code;
  } peer_word_t;
endpackage

// File: rtl/rrs_ring_select.sv
module rrs_ring_select
  import rrs_pkg::*;
#(
  parameter int NUM_KINDS = 4,
  localparam int KIND_W   = $clog2(NUM_KINDS)
) (
  input  logic [KIND_W-1:0]           kind_i,
  input  logic [NUM_OVR_KINDS-1:0]    ovr_i,
  input  logic [RING_W-1:0]           word_src_i,
  input  logic [RING_W-1:0]           word_dst_i,
  input  logic                        echo_drop_i,
  input  logic                        echo_flag_i,
  input  logic [NUM_KINDS*RING_W-1:0] cfg_src_i,
  input  logic [NUM_KINDS*RING_W-1:0] cfg_dst_i,
  output logic [RING_W-1:0]           src_o,
  output logic [RING_W-1:0]           dst_o,
  output logic                        err_o
);
  logic [RING_W-1:0]    src_tab [NUM_KINDS];
  logic [RING_W-1:0]    dst_tab [NUM_KINDS];
  logic [NUM_KINDS-1:0] ovr_vec;
  logic [RING_W-1:0]    sel_src, sel_dst;
  logic                 bad_code, echo_hit;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    assign src_tab[k] = cfg_src_i[k*RING_W +: RING_W];
    assign dst_tab[k] = cfg_dst_i[k*RING_W +: RING_W];
    if (k < NUM_OVR_KINDS) begin : g_ovr
      assign ovr_vec[k] = ovr_i[k];
    end else begin : g_fixed
      assign ovr_vec[k] = 1'b0;
    end
  end

  always_comb begin
    if (ovr_vec[kind_i]) begin
      sel_src = word_src_i;
      sel_dst = word_dst_i;
    end else begin
      sel_src = src_tab[kind_i];
      sel_dst = dst_tab[kind_i];
    end
    bad_code = (sel_src > SRC_MAX) || (sel_dst > DST_MAX);
    echo_hit = (kind_i == KIND_MCAST) && echo_drop_i && echo_flag_i;
    src_o    = sel_src;
    dst_o    = (bad_code || echo_hit) ? DST_RELEASE : sel_dst;
    err_o    = bad_code;
  end

  always_comb begin
    assert_dst_legal_R9: assert (dst_o <= DST_MAX);
    if (echo_hit) begin
      assert_echo_release_R8: assert (dst_o == DST_RELEASE);
    end
  end
endmodule

// File: rtl/rrs_exit_select.sv
module rrs_exit_select
  import rrs_pkg::*;
#(
  localparam int NUM_CODES = 1 << EXIT_W
) (
  input  logic [EXIT_W-1:0]           code_i,
  input  logic [PEER_W-1:0]           peer_hi_i,
  input  logic                        fb_en_i,
  input  logic                        flow_hit_i,
  input  logic [3:0]                  hash_i,
  input  logic                        ppe_req_i,
  input  logic                        ppe_gate_i,
  input  logic                        multi_buf_i,
  input  logic                        mbuf_off_i,
  input  logic [EXIT_W-1:0]           ppe_code_i,
  input  logic [NUM_CODES*EXIT_W-1:0] remap_i,
  input  logic [OPT_RINGS-1:0]        present_i,
  output logic [EXIT_W-1:0]           code_o
);
  logic [EXIT_W-1:0]    remap_tab [NUM_CODES];
  logic [NUM_CODES-1:0] needs_remap;
  logic [EXIT_W-1:0]    fb_code, pre_code, post_code;
  logic                 fb_active, ppe_active;

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    assign remap_tab[c] = remap_i[c*EXIT_W +: EXIT_W];
    if (c < FIRST_OPT) begin : g_real
      assign needs_remap[c] = 1'b0;
    end else if (c < FIRST_OPT + OPT_RINGS) begin : g_opt
      assign needs_remap[c] = ~present_i[c-FIRST_OPT];
    end else begin : g_virt
      assign needs_remap[c] = 1'b1;
    end
  end

  always_comb begin
    fb_active = fb_en_i && !flow_hit_i;
    if (peer_hi_i == '0) fb_code = {1'b1, hash_i};
    else                 fb_code = {peer_hi_i, hash_i[2:0]};
    pre_code   = fb_active ? fb_code : code_i;
    post_code  = needs_remap[pre_code] ? remap_tab[pre_code] : pre_code;
    ppe_active = ppe_req_i && ppe_gate_i && !(multi_buf_i && mbuf_off_i);
    code_o     = ppe_active ? ppe_code_i : post_code;
  end

  always_comb begin
    if (!fb_active && !ppe_active && code_i < EXIT_W'(FIRST_OPT)) begin
      assert_low_passthru_R6: assert (code_o == code_i);
    end
  end
endmodule

// File: rtl/rx_ring_router.sv
module rx_ring_router
  import rrs_pkg::*;
#(
  parameter int NUM_KINDS  = 4,
  localparam int KIND_W    = $clog2(NUM_KINDS),
  localparam int NUM_CODES = 1 << EXIT_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [31:0]                 class_word,
  input  logic [KIND_W-1:0]           frame_kind,
  input  logic                        flow_hit,
  input  logic [3:0]                  flow_hash,
  input  logic                        multi_buf,
  input  logic                        echo_flag,
  input  logic [NUM_KINDS*RING_W-1:0] cfg_src_rings,
  input  logic [NUM_KINDS*RING_W-1:0] cfg_dst_rings,
  input  logic [EXIT_W-1:0]           cfg_ppe_ring,
  input  logic [NUM_CODES*EXIT_W-1:0] cfg_remap,
  input  logic [OPT_RINGS-1:0]        cfg_ring_present,
  input  logic                        cfg_mbuf_ppe_off,
  output logic                        out_valid,
  output logic [RING_W-1:0]           out_src_ring,
  output logic [RING_W-1:0]           out_dst_ring,
  output logic [EXIT_W-1:0]           out_exit_ring,
  output logic                        out_err
);
  peer_word_t        pw;
  logic [RING_W-1:0] c_src, c_dst;
  logic [EXIT_W-1:0] c_exit;
  logic              c_err;
  logic              unused_rsvd;

  logic              valid_q, valid_d, err_q, err_d;
  logic [RING_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [EXIT_W-1:0] exit_q, exit_d;

  assign pw          = peer_word_t'(class_word);
  assign unused_rsvd = ^{pw.rsvd_hi, pw.rsvd_mid};

  rrs_ring_select #(.NUM_KINDS(NUM_KINDS)) u_rings (
    .kind_i      (frame_kind),
    .ovr_i       (pw.ovr),
    .word_src_i  (pw.src),
    .word_dst_i  (pw.dst),
    .echo_drop_i (pw.echo_drop),
    .echo_flag_i (echo_flag),
    .cfg_src_i   (cfg_src_rings),
    .cfg_dst_i   (cfg_dst_rings),
    .src_o       (c_src),
    .dst_o       (c_dst),
    .err_o       (c_err)
  );

  rrs_exit_select u_exit (
    .code_i      (pw.exit_code),
    .peer_hi_i   (pw.peer_hi),
    .fb_en_i     (pw.fb_en),
    .flow_hit_i  (flow_hit),
    .hash_i      (flow_hash),
    .ppe_req_i   (pw.ppe_req),
    .ppe_gate_i  (pw.ppe_gate),
    .multi_buf_i (multi_buf),
    .mbuf_off_i  (cfg_mbuf_ppe_off),
    .ppe_code_i  (cfg_ppe_ring),
    .remap_i     (cfg_remap),
    .present_i   (cfg_ring_present),
    .code_o      (c_exit)
  );

  // Next-state: results load only on an accepted frame
  always_comb begin
    valid_d = in_valid;
    err_d   = in_valid && c_err;
    src_d   = src_q;
    dst_d   = dst_q;
    exit_d  = exit_q;
    if (in_valid) begin
      src_d  = c_src;
      dst_d  = c_dst;
      exit_d = c_exit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      exit_q  <= '0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      exit_q  <= exit_d;
    end
  end

  assign out_valid     = valid_q;
  assign out_err       = err_q;
  assign out_src_ring  = src_q;
  assign out_dst_ring  = dst_q;
  assign out_exit_ring = exit_q;

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err && $stable(out_exit_ring)
                   && $stable(out_src_ring) && $stable(out_dst_ring)));
  assert_err_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_dst_ring == DST_RELEASE));
endmodule

// File: tb/tb_rx_ring_router.sv
`timescale 1ns/1ps
module tb_rx_ring_router;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  class_word;
  logic [1:0]   frame_kind;
  logic         flow_hit, multi_buf, echo_flag, cfg_mbuf_ppe_off;
  logic [3:0]   flow_hash;
  logic [11:0]  cfg_src_rings, cfg_dst_rings;
  logic [4:0]   cfg_ppe_ring;
  logic [159:0] cfg_remap;
  logic [3:0]   cfg_ring_present;
  logic         out_valid, out_err;
  logic [2:0]   out_src_ring, out_dst_ring;
  logic [4:0]   out_exit_ring;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int remap_tab[32];
  int cfg_s[4] = '{2, 0, 4, 1};
  int cfg_d[4] = '{3, 2, 1, 4};
  bit e_valid, e_err;
  int e_src, e_dst, e_exit;

  always #2.5 clk = ~clk;

  rx_ring_router dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .class_word(class_word),
    .frame_kind(frame_kind), .flow_hit(flow_hit), .flow_hash(flow_hash),
    .multi_buf(multi_buf), .echo_flag(echo_flag),
    .cfg_src_rings(cfg_src_rings), .cfg_dst_rings(cfg_dst_rings),
    .cfg_ppe_ring(cfg_ppe_ring), .cfg_remap(cfg_remap),
    .cfg_ring_present(cfg_ring_present), .cfg_mbuf_ppe_off(cfg_mbuf_ppe_off),
    .out_valid(out_valid), .out_src_ring(out_src_ring),
    .out_dst_ring(out_dst_ring), .out_exit_ring(out_exit_ring), .out_err(out_err)
  );

  function automatic logic [31:0] mkword(int code, int peer, bit fb, int ovr,
                                         int src, int dst, bit echo_en,
                                         bit ppe_req, bit ppe_gate);
    logic [31:0] w = '0;
    w[4:0]   = code[4:0];
    w[6:5]   = peer[1:0];
    w[7]     = fb;
    w[10:8]  = ovr[2:0];
    w[13:11] = src[2:0];
    w[16:14] = dst[2:0];
    w[17]    = echo_en;
    w[20]    = ppe_req;
    w[21]    = ppe_gate;
    return w;
  endfunction

  // Behavioural reference of the requirements
  task automatic model(logic [31:0] w, int kind, bit hit, int h, bit mb, bit echo);
    int c, s, d;
    bit ovr, bad;
    c = int'(w[4:0]);
    if (w[7] && !hit) begin
      if (w[6:5] == 0) c = 16 + (h % 16);
      else             c = int'(w[6:5]) * 8 + (h % 8);
    end
    if (c >= 11 || (c >= 7 && !cfg_ring_present[c-7])) c = remap_tab[c];
    if (w[20] && w[21] && !(mb && cfg_mbuf_ppe_off)) c = int'(cfg_ppe_ring);
    ovr = (kind < 3) && w[8+kind];
    s = ovr ? int'(w[13:11]) : cfg_s[kind];
    d = ovr ? int'(w[16:14]) : cfg_d[kind];
    bad = (s > 5) || (d > 6);
    if (bad) d = 0;
    if (kind == 1 && w[17] && echo) d = 0;
    e_src = s; e_dst = d; e_exit = c; e_err = bad;
  endtask

  task automatic check(string tag);
    checks++;
    if (out_valid !== e_valid || out_err !== e_err || int'(out_src_ring) != e_src ||
        int'(out_dst_ring) != e_dst || int'(out_exit_ring) != e_exit) begin
      failures++;
      $display("FAIL %s: valid/src/dst/exit/err actual %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
               tag, out_valid, out_src_ring, out_dst_ring, out_exit_ring, out_err,
               e_valid, e_src, e_dst, e_exit, e_err);
    end
  endtask

  task automatic step(bit v, logic [31:0] w, int kind, bit hit, int h, bit mb,
                      bit echo, string tag);
    in_valid = v; class_word = w; frame_kind = kind[1:0]; flow_hit = hit;
    flow_hash = h[3:0]; multi_buf = mb; echo_flag = echo;
    if (v) model(w, kind, hit, h, mb, echo);
    else e_err = 0;
    e_valid = v;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 0; class_word = '0; frame_kind = 0; flow_hit = 0; flow_hash = 0;
    multi_buf = 0; echo_flag = 0; cfg_mbuf_ppe_off = 0;
    for (int c = 0; c < 32; c++) begin
      remap_tab[c] = (c * 7 + 3) % 32;
      cfg_remap[c*5 +: 5] = 5'(remap_tab[c]);
    end
    for (int k = 0; k < 4; k++) begin
      cfg_src_rings[k*3 +: 3] = 3'(cfg_s[k]);
      cfg_dst_rings[k*3 +: 3] = 3'(cfg_d[k]);
    end
    cfg_ppe_ring = 5'd19;
    cfg_ring_present = 4'b0101;
    e_valid = 0; e_err = 0; e_src = 0; e_dst = 0; e_exit = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");

    // R3 overrides per kind
    step(1, mkword(2, 0, 0, 3'b001, 5, 6, 0, 0, 0), 0, 1, 0, 0, 0, "R3");
    step(1, mkword(2, 0, 0, 3'b110, 5, 6, 0, 0, 0), 0, 1, 0, 0, 0, "R3");
    step(1, mkword(3, 0, 0, 3'b010, 1, 5, 0, 0, 0), 1, 1, 0, 0, 0, "R3");
    step(1, mkword(4, 0, 0, 3'b100, 2, 3, 0, 0, 0), 2, 1, 0, 0, 0, "R3");
    step(1, mkword(4, 0, 0, 3'b111, 2, 3, 0, 0, 0), 3, 1, 0, 0, 0, "R3");
    // R4 and R5 hash fallback
    step(1, mkword(1, 0, 1, 0, 0, 0, 0, 0, 0), 0, 0, 5, 0, 0, "R4");
    step(1, mkword(1, 0, 1, 0, 0, 0, 0, 0, 0), 0, 0, 15, 0, 0, "R4");
    step(1, mkword(1, 2, 1, 0, 0, 0, 0, 0, 0), 0, 0, 13, 0, 0, "R5");
    step(1, mkword(1, 1, 1, 0, 0, 0, 0, 0, 0), 0, 0, 6, 0, 0, "R5");
    step(1, mkword(1, 3, 1, 0, 0, 0, 0, 0, 0), 0, 1, 6, 0, 0, "R5");
    step(1, mkword(1, 3, 0, 0, 0, 0, 0, 0, 0), 0, 0, 6, 0, 0, "R5");
    // R6 remap
    step(1, mkword(7, 0, 0, 0, 0, 0, 0, 0, 0), 0, 1, 0, 0, 0, "R6");
    step(1, mkword(8, 0, 0, 0, 0, 0, 0, 0, 0), 0, 1, 0, 0, 0, "R6");
    step(1, mkword(10, 0, 0, 0, 0, 0, 0, 0, 0), 0, 1, 0, 0, 0, "R6");
    step(1, mkword(12, 0, 0, 0, 0, 0, 0, 0, 0), 0, 1, 0, 0, 0, "R6");
    step(1, mkword(6, 0, 0, 0, 0, 0, 0, 0, 0), 0, 1, 0, 0, 0, "R6");
    // R7 PPE override layers
    step(1, mkword(3, 0, 0, 0, 0, 0, 0, 1, 1), 0, 1, 0, 0, 0, "R7");
    step(1, mkword(3, 0, 0, 0, 0, 0, 0, 1, 0), 0, 1, 0, 0, 0, "R7");
    step(1, mkword(20, 0, 0, 0, 0, 0, 0, 1, 1), 0, 1, 0, 1, 0, "R7");
    cfg_mbuf_ppe_off = 1;
    step(1, mkword(20, 0, 0, 0, 0, 0, 0, 1, 1), 0, 1, 0, 1, 0, "R7");
    step(1, mkword(20, 0, 0, 0, 0, 0, 0, 1, 1), 0, 1, 0, 0, 0, "R7");
    cfg_mbuf_ppe_off = 0;
    // R8 echo drop
    step(1, mkword(2, 0, 0, 3'b010, 1, 5, 1, 0, 0), 1, 1, 0, 0, 1, "R8");
    step(1, mkword(2, 0, 0, 3'b010, 1, 5, 0, 0, 0), 1, 1, 0, 0, 1, "R8");
    step(1, mkword(2, 0, 0, 3'b001, 1, 5, 1, 0, 0), 0, 1, 0, 0, 1, "R8");
    // R9 illegal codes
    step(1, mkword(2, 0, 0, 3'b001, 6, 3, 0, 0, 0), 0, 1, 0, 0, 0, "R9");
    step(1, mkword(2, 0, 0, 3'b001, 2, 7, 0, 0, 0), 0, 1, 0, 0, 0, "R9");
    cfg_s[2] = 7; cfg_src_rings[8:6] = 3'd7;
    step(1, mkword(2, 0, 0, 0, 0, 0, 0, 0, 0), 2, 1, 0, 0, 0, "R9");
    cfg_s[2] = 4; cfg_src_rings[8:6] = 3'd4;
    // R2 idle gap holds results
    step(0, mkword(9, 0, 0, 0, 0, 0, 0, 0, 0), 1, 1, 0, 0, 0, "R2");
    step(0, '0, 0, 0, 0, 0, 0, "R2");
    // R10 reserved bits
    step(1, mkword(5, 1, 1, 3'b001, 2, 6, 0, 0, 1) | 32'hFFCC_0000, 0, 0, 9, 0, 0, "R10");
    step(1, mkword(5, 1, 1, 3'b001, 2, 6, 0, 0, 1), 0, 0, 9, 0, 0, "R10");
    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      int kd, hh;
      kd = int'($urandom % 4);
      hh = int'($urandom % 16);
      cfg_mbuf_ppe_off = 1'($urandom);
      step(1'($urandom % 4 != 0), $urandom, kd, 1'($urandom), hh,
           1'($urandom), 1'($urandom), "R2");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule